// File: doc/BRIEF.md
# Power-Down Entry and Exit Sequencer

This block steps a programmable device into and out of its low-power state. The input is an active-low request pin, and the block runs on a free-running reference clock. A request is honoured only when the pin has stayed low for a minimum pulse width. Once it is honoured, the block shuts down the device's boundary in a fixed order.

On entry, the input buffers are disabled, the sensed inputs are forced to logic 0, the internal pull-ups are switched off and the global set/reset is asserted, all in the same cycle. The output buffers follow one gap later. On exit, the block runs the same steps in reverse. It reports ready only after a settle time has passed.

Every delay is given in nanoseconds and turned into whole clock cycles by rounding up, based on the clock-period parameter. The program-request input passes through untouched at all times. Control and status pins are plain levels; there is no streaming interface and so there is no back-pressure.

Top module: `pwrdn_seq`

## Requirements
- R1: The pin, after a two-stage synchroniser, must read low for MIN_CYC = ceil(MIN_PULSE_NS/CLK_PERIOD_NS) consecutive clock samples before power-down starts. A shorter low pulse is ignored: `ready` stays 1, every control output stays 0 and `sig_out` keeps following `sig_in`.
- R2: On entry, `in_buf_off` and `gsr` rise in the same cycle. `out_buf_off` rises exactly GAP_CYC = ceil(OUT_GAP_NS/CLK_PERIOD_NS) cycles later.
- R3: While `in_buf_off` is 1, every bit of `sig_out` is 0 whatever `sig_in` holds, and `pullup_off` equals `in_buf_off`.
- R4: `prog_n_out` equals `prog_n_in` in every cycle, whatever the power-down state.
- R5: On exit, `in_buf_off`, `pullup_off` and `gsr` fall in the same cycle. `out_buf_off` falls exactly GAP_CYC cycles later.
- R6: `ready` falls in the cycle entry begins. It rises SETTLE_CYC = ceil(SETTLE_NS/CLK_PERIOD_NS) cycles after the exit starts, which is at least SETTLE_NS after the pin returned high.
- R7: After reset, the pin reads as high (the pulled-up default), `ready` is 1, all control outputs are 0, and `sig_out` follows `sig_in`.
- R8: If the synchronised pin goes low again before `ready` rises, the block goes back to power-down without the pulse filter. In that case `gsr` rises three clock edges after the pin fell, keeping entry order, and `ready` never rises in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_pin_n | input | 1 | Active-low power-down request pin |
| sig_in | input | SIG_W | Sensed device inputs (mode, done, configuration clock, test data out, user) |
| prog_n_in | input | 1 | Program request, never gated |
| sig_out | output | SIG_W | Sensed inputs after forcing to 0 |
| prog_n_out | output | 1 | Program request passed through |
| in_buf_off | output | 1 | Input buffer disable |
| pullup_off | output | 1 | Internal pull-up disable |
| gsr | output | 1 | Global set/reset assert |
| out_buf_off | output | 1 | Output buffer disable |
| ready | output | 1 | Device usable |

## Verification
The bench sweeps the low-pulse length from one to six cycles across the filter threshold. A filter that is off by one would either act on a two-cycle glitch or drop a three-cycle request. For each accepted pulse it measures the cycle distance between the input-side and output-side edges on entry and on exit, and the delay from the start of the exit to ready. Swapped ordering or a lost gap cycle shows up as a wrong distance. It also pulls the pin low again while the exit is still in progress. A design that filters this second request or passes through the active state would let ready rise or raise global set/reset late.

// File: rtl/pd_pkg.sv
package pd_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_ENTRY  = 3'd1,
    ST_DOWN   = 3'd2,
    ST_EXIT   = 3'd3,
    ST_SETTLE = 3'd4
  } pd_state_e;

  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/pd_filter.sv
module pd_filter #(
  parameter int MIN_CYC = 3,
  localparam int CW = $clog2(MIN_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_sync_n,
  output logic low_now,
  output logic req_hold
);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          low_cnt <= '0;
    else if (pin_sync_n)                 low_cnt <= '0;
    else if (low_cnt != CW'(MIN_CYC))    low_cnt <= low_cnt + 1'b1;
  end

  assign low_now  = !pin_sync_n;
  assign req_hold = (low_cnt == CW'(MIN_CYC));

  AST_HOLD_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_hold) |-> $past(!pin_sync_n)); // R1
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import pd_pkg::*;
#(
  parameter int GAP_CYC    = 1,
  parameter int SETTLE_CYC = 3,
  localparam int SET_EFF   = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC + 1,
  localparam int CW        = $clog2(SET_EFF + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_hold,
  input  logic low_now,
  output logic in_off,
  output logic gsr,
  output logic out_off,
  output logic ready
);
  pd_state_e     state, state_nx;
  logic [CW-1:0] cnt, cnt_nx;

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    case (state)
      ST_ACTIVE: if (req_hold) begin state_nx = ST_ENTRY; cnt_nx = '0; end
      ST_ENTRY: begin
        if (cnt == CW'(GAP_CYC - 1)) state_nx = ST_DOWN;
        else                         cnt_nx   = cnt + 1'b1;
      end
      ST_DOWN: if (!low_now) begin state_nx = ST_EXIT; cnt_nx = '0; end
      ST_EXIT: begin
        if (low_now) state_nx = ST_DOWN;
        else begin
          cnt_nx = cnt + 1'b1;
          if (cnt == CW'(GAP_CYC - 1)) state_nx = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (low_now) begin state_nx = ST_ENTRY; cnt_nx = '0; end
        else if (cnt == CW'(SET_EFF - 1)) state_nx = ST_ACTIVE;
        else cnt_nx = cnt + 1'b1;
      end
      default: begin state_nx = ST_ACTIVE; cnt_nx = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_ACTIVE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end

  always_comb begin
    in_off  = (state == ST_ENTRY) || (state == ST_DOWN);
    gsr     = in_off;
    out_off = (state == ST_DOWN) || (state == ST_EXIT);
    ready   = (state == ST_ACTIVE);
  end

  AST_ENTRY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_off) |-> $past(in_off)); // R2
  AST_NO_SKIP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_ACTIVE) |-> (state != ST_DOWN)); // R2
  AST_EXIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_off) |-> (!$past(in_off) && !gsr)); // R5
  AST_READY_AFTER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(!out_off)); // R6
  AST_ENTRY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gsr) && $past(state) == ST_ACTIVE) |-> $past(req_hold)); // R1
endmodule

// File: rtl/pd_gate.sv
module pd_gate #(
  parameter int SIG_W = 8
) (
  input  logic             force_low,
  input  logic [SIG_W-1:0] sig_in,
  input  logic             prog_n_in,
  output logic [SIG_W-1:0] sig_out,
  output logic             prog_n_out
);
  for (genvar i = 0; i < SIG_W; i++) begin : g_bit
    assign sig_out[i] = sig_in[i] & ~force_low;
  end
  assign prog_n_out = prog_n_in;
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pd_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int MIN_PULSE_NS  = 50,
  parameter int OUT_GAP_NS    = 10,
  parameter int SETTLE_NS     = 50,
  parameter int SIG_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_pin_n,
  input  logic [SIG_W-1:0] sig_in,
  input  logic             prog_n_in,
  output logic [SIG_W-1:0] sig_out,
  output logic             prog_n_out,
  output logic             in_buf_off,
  output logic             pullup_off,
  output logic             gsr,
  output logic             out_buf_off,
  output logic             ready
);
  localparam int MIN_CYC    = ns_to_cyc(MIN_PULSE_NS, CLK_PERIOD_NS);
  localparam int GAP_CYC    = ns_to_cyc(OUT_GAP_NS, CLK_PERIOD_NS);
  localparam int SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_PERIOD_NS);

  logic pin_sync_n, low_now, req_hold, in_off;

  pd_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pd_pin_n), .d_sync(pin_sync_n)
  );

  pd_filter #(.MIN_CYC(MIN_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin_sync_n(pin_sync_n),
    .low_now(low_now), .req_hold(req_hold)
  );

  pd_fsm #(.GAP_CYC(GAP_CYC), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_hold(req_hold), .low_now(low_now),
    .in_off(in_off), .gsr(gsr), .out_off(out_buf_off), .ready(ready)
  );

  pd_gate #(.SIG_W(SIG_W)) u_gate (
    .force_low(in_off), .sig_in(sig_in), .prog_n_in(prog_n_in),
    .sig_out(sig_out), .prog_n_out(prog_n_out)
  );

  assign in_buf_off = in_off;
  assign pullup_off = in_off;

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (sig_out == sig_in)); // R7
endmodule

// File: tb/pwrdn_seq_tb.sv
module pwrdn_seq_tb;
  localparam int PER    = 20;
  localparam int SIG_W  = 8;
  localparam int MIN_C  = (50 + PER - 1) / PER;
  localparam int GAP_C  = ((10 + PER - 1) / PER < 1) ? 1 : (10 + PER - 1) / PER;
  localparam int SET_C  = (50 + PER - 1) / PER;

  logic clk = 0, rst_n = 0, pd_pin_n = 1, prog_n_in = 1;
  logic [SIG_W-1:0] sig_in = '1;
  logic [SIG_W-1:0] sig_out;
  logic prog_n_out, in_buf_off, pullup_off, gsr, out_buf_off, ready;

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  pwrdn_seq #(.CLK_PERIOD_NS(PER), .SIG_W(SIG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pd_pin_n(pd_pin_n), .sig_in(sig_in),
    .prog_n_in(prog_n_in), .sig_out(sig_out), .prog_n_out(prog_n_out),
    .in_buf_off(in_buf_off), .pullup_off(pullup_off), .gsr(gsr),
    .out_buf_off(out_buf_off), .ready(ready)
  );

  always #(PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  int in_rise, in_fall, g_rise, g_fall, o_rise, o_fall, r_rise, r_fall;
  int gsr_rises;
  bit p_in, p_g, p_o, p_r, ready_rose, force_bad, pull_bad, prog_bad;

  always @(negedge clk) begin
    if (rst_n) begin
      if (in_buf_off && !p_in) in_rise = cyc;
      if (!in_buf_off && p_in) in_fall = cyc;
      if (gsr && !p_g) begin g_rise = cyc; gsr_rises++; end
      if (!gsr && p_g) g_fall = cyc;
      if (out_buf_off && !p_o) o_rise = cyc;
      if (!out_buf_off && p_o) o_fall = cyc;
      if (ready && !p_r) begin r_rise = cyc; ready_rose = 1; end
      if (!ready && p_r) r_fall = cyc;
      if (in_buf_off && sig_out != '0) force_bad = 1;
      if (pullup_off != in_buf_off) pull_bad = 1;
      if (prog_n_out != prog_n_in) prog_bad = 1;
      p_in = in_buf_off; p_g = gsr; p_o = out_buf_off; p_r = ready;
      prog_n_in <= ~prog_n_in;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    in_rise = -1; in_fall = -1; g_rise = -1; g_fall = -1;
    o_rise = -1; o_fall = -1; r_rise = -1; r_fall = -1;
    gsr_rises = 0; ready_rose = 0; force_bad = 0; pull_bad = 0; prog_bad = 0;
  endtask

  task automatic pulse(input int len);
    int pin_up;
    bit acc;
    clr();
    @(negedge clk); pd_pin_n = 0;
    repeat (len) @(negedge clk);
    pd_pin_n = 1; pin_up = cyc;
    repeat (25) @(negedge clk);
    acc = (len >= MIN_C);
    chk((gsr_rises > 0) == acc, "R1 accept", gsr_rises, int'(acc));
    chk(ready == 1, "R6 ready back", ready, 1);
    chk(!prog_bad, "R4 prog pass", prog_bad, 0);
    if (acc) begin
      chk(g_rise == in_rise, "R2 gsr with inputs", g_rise, in_rise);
      chk(o_rise - in_rise == GAP_C, "R2 output gap", o_rise - in_rise, GAP_C);
      chk(r_fall == in_rise, "R6 ready falls at entry", r_fall, in_rise);
      chk(!force_bad && !pull_bad, "R3 force/pullups", force_bad, 0);
      chk(g_fall == in_fall, "R5 gsr release", g_fall, in_fall);
      chk(o_fall - in_fall == GAP_C, "R5 output gap", o_fall - in_fall, GAP_C);
      chk(r_rise - in_fall == SET_C, "R6 settle", r_rise - in_fall, SET_C);
      chk((r_rise - pin_up) * PER >= 50, "R6 50ns after pin", (r_rise - pin_up) * PER, 50);
    end else begin
      chk(!ready_rose && r_fall == -1, "R1 ignored ready", r_fall, -1);
      chk(in_rise == -1 && o_rise == -1, "R1 ignored ctrl", o_rise, -1);
    end
  endtask

  initial begin
    #(PER * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clr();
    p_in = 0; p_g = 0; p_o = 0; p_r = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ready == 1, "R7 ready", ready, 1);
    chk({in_buf_off, pullup_off, gsr, out_buf_off} == 4'b0, "R7 ctrl",
        {in_buf_off, pullup_off, gsr, out_buf_off}, 0);
    chk(sig_out == sig_in, "R7 sig pass", sig_out, sig_in);
    for (int len = 1; len <= 6; len++) pulse(len);
    sig_in = 8'hA5;
    pulse(MIN_C + 4);
    // R8: low again during exit
    clr();
    @(negedge clk); pd_pin_n = 0;
    repeat (MIN_C + 6) @(negedge clk);
    pd_pin_n = 1;
    while (in_buf_off) @(negedge clk);
    pd_pin_n = 0;
    clr(); p_r = ready;
    repeat (3) @(negedge clk);
    chk(gsr == 1, "R8 fast reentry", gsr, 1);
    chk(!ready_rose, "R8 ready held", ready_rose, 0);
    repeat (GAP_C) @(negedge clk);
    chk(out_buf_off == 1 && in_buf_off == 1, "R8 down", out_buf_off, 1);
    pd_pin_n = 1;
    repeat (25) @(negedge clk);
    chk(ready == 1 && !in_buf_off && !out_buf_off, "R8 recovers", ready, 1);
    chk(!force_bad && !prog_bad, "R3 R4 during reentry", force_bad, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule